// File: doc/BRIEF.md
# Retention Pause Test Sequencer

This block drives a March-style data-retention test on a single-port SRAM. On a start request it writes an all-zero background to every word, leaves the array untouched for a retention interval, and reads every word back, comparing each result with the background. It then repeats the same three elements with an all-one background. A one-cycle done pulse closes the test. Any mismatch raises a sticky fail flag and records the first failing address and the background value that was expected there.

The required retention interval is given as a cycle count. The block does not add that full count as an idle wait. Every cell has already been left alone for part of the interval while the rest of the array was being written. The block counts the cycles of each write sweep and idles only for the part of the interval that is still missing. The wait is computed as a saturating difference. On a large array the sweep alone can cover the whole interval, and the read element then follows the last write with no idle cycle at all.

Addresses are walked with the row index changing fastest and the column index changing slowest. The memory is modelled with one cycle of read latency.

Top module: `retention_pause_seq`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, mem_we_o and mem_re_o are all 0.
- R2: A test runs six elements in this order: write background 0 to every address, wait, read every address expecting 0, write background 1 to every address, wait, read every address expecting 1. Each access element touches each of the 2^(ROW_BITS+COL_BITS) addresses exactly once. One idle cycle follows each read element.
- R3: The address is {column, row}, with the row in the low ROW_BITS bits. The row field steps fastest, so the addresses in one element appear as 0, 1, 2, … up to the last. Defaults are 9 row bits and 8 column bits.
- R4: With N words and a pause of P cycles, the explicit wait after each write element lasts max(P − N, 0) cycles. The first read of an element therefore comes max(P, N) cycles after the first write of the element before it.
- R5: When P ≤ N, the first read (address 0) is issued in the cycle right after the last write.
- R6: During a wait, neither mem_we_o nor mem_re_o is asserted.
- R7: A read word that differs in any bit from the expected background sets fail_o. fail_o stays set until the next accepted start, which clears it. fail_addr_o and fail_exp_o hold the address and expected bit of the first mismatch only.
- R8: done_o is high for exactly one cycle, in the cycle after the idle cycle that follows the second read element. busy_o is low in that cycle.
- R9: start_i has no effect while busy_o is high.
- R10: Every bit of mem_wdata_o equals the current background during writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a test when idle |
| pause_cycles_i | input | PAUSE_W | Required retention interval in cycles, captured at start |
| mem_addr_o | output | ROW_BITS+COL_BITS | SRAM address, {column, row} |
| mem_we_o | output | 1 | SRAM write enable |
| mem_re_o | output | 1 | SRAM read enable |
| mem_wdata_o | output | DATA_W | SRAM write data (background replicated) |
| mem_rdata_i | input | DATA_W | SRAM read data, valid one cycle after mem_re_o |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle end-of-test pulse |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | ROW_BITS+COL_BITS | Address of the first mismatch |
| fail_exp_o | output | 1 | Expected background bit at the first mismatch |

## Verification
The test is run with pause lengths below, equal to, one above and far above the sweep length. These separate the direct write-to-read hand-off from the shortened wait and confirm that the saturating difference does not overflow. Every cycle of each run is compared with a trace computed from the pause and the array size. Cell faults that fail to hold 0 or fail to hold 1 are placed at the first address, the last address, random addresses, and at two addresses of the same polarity. These runs tell whether the first-mismatch capture, the expected value and the clearing on restart are correct. Start pulses issued in the middle of a run check that a running test is not disturbed.

// File: rtl/rps_pkg.sv
// Shared types for the retention pause test sequencer.
package rps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_WAIT,
        ST_READ,
        ST_FLUSH
    } seq_state_t;
endpackage

// File: rtl/rps_addr_walk.sv
// Address walker: steps through every word with the row index changing
// fastest. Assumes one step per access cycle; wraps to zero after the last word.
module rps_addr_walk #(
    parameter int ROW_BITS = 9,
    parameter int COL_BITS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    input  logic                         step_i,
    output logic [ROW_BITS+COL_BITS-1:0] addr_o,
    output logic                         last_o
);
    logic [ROW_BITS-1:0] row_q;
    logic [COL_BITS-1:0] col_q;

    // Row advances each step; column advances when the row wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            row_q <= '0;
            col_q <= '0;
        end else if (step_i) begin
            if (&row_q) begin
                row_q <= '0;
                col_q <= col_q + 1'b1;
            end else begin
                row_q <= row_q + 1'b1;
            end
        end
    end

    assign addr_o = {col_q, row_q};
    assign last_o = (&row_q) && (&col_q);

    // R3: the column only moves on a row wrap
    a_r3_col_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && !(&row_q)) |=> $stable(col_q));
endmodule

// File: rtl/rps_hold_timer.sv
// Retention timer: counts the cycles of the current write sweep and, at the
// last write, loads the missing part of the pause (saturating at zero).
// Assumes pause_i is stable during a test.
module rps_hold_timer #(
    parameter int ADDR_W  = 17,
    parameter int PAUSE_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               tick_i,
    input  logic               load_i,
    input  logic [PAUSE_W-1:0] pause_i,
    output logic               skip_o,
    output logic               expire_o,
    output logic               waiting_o
);
    localparam int SW = ADDR_W + 1;
    localparam int CW = ((PAUSE_W > SW) ? PAUSE_W : SW) + 1;

    logic [SW-1:0] sweep_q;
    logic [CW-1:0] wait_q;
    logic [CW-1:0] need_w, swept_w, remain_w;

    // The sweep includes the write happening in the load cycle.
    assign need_w   = CW'(pause_i);
    assign swept_w  = CW'(sweep_q) + CW'(1);
    assign remain_w = (need_w > swept_w) ? (need_w - swept_w) : '0;

    assign skip_o    = (remain_w == '0);
    assign expire_o  = (wait_q == CW'(1));
    assign waiting_o = (wait_q != '0);

    // Count sweep cycles and run down the remaining wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_q <= '0;
            wait_q  <= '0;
        end else begin
            if (clr_i)       sweep_q <= '0;
            else if (tick_i) sweep_q <= sweep_q + 1'b1;
            if (load_i)          wait_q <= remain_w;
            else if (waiting_o)  wait_q <= wait_q - 1'b1;
        end
    end

    // R4: a non-skipped load always starts a wait
    a_r4_wait_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !skip_o) |=> waiting_o);
endmodule

// File: rtl/rps_read_check.sv
// Read checker: compares read data one cycle after each read against the
// replicated background and keeps the first mismatch. Assumes one-cycle
// read latency.
module rps_read_check #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              exp_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic              fail_exp_o
);
    logic              pend_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic              pend_exp_q;
    logic              miss_w;

    assign miss_w = pend_q && (rdata_i != {DATA_W{pend_exp_q}});

    // Track the read in flight, then record only the first mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
            pend_exp_q  <= 1'b0;
            fail_o      <= 1'b0;
            fail_addr_o <= '0;
            fail_exp_o  <= 1'b0;
        end else begin
            pend_q      <= rd_en_i;
            pend_addr_q <= rd_addr_i;
            pend_exp_q  <= exp_i;
            if (clr_i) begin
                fail_o      <= 1'b0;
                fail_addr_o <= '0;
                fail_exp_o  <= 1'b0;
            end else if (miss_w && !fail_o) begin
                fail_o      <= 1'b1;
                fail_addr_o <= pend_addr_q;
                fail_exp_o  <= pend_exp_q;
            end
        end
    end

    // R7: once set, the flag and capture hold until cleared
    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !clr_i) |=> (fail_o && $stable(fail_addr_o) && $stable(fail_exp_o)));
endmodule

// File: rtl/retention_pause_seq.sv
// Retention pause test sequencer: write 0 / wait / read 0 / write 1 / wait /
// read 1 over the whole array. The wait after each write sweep is shortened
// by the sweep length. Assumes a single-port SRAM with one-cycle read latency.
module retention_pause_seq
    import rps_pkg::*;
#(
    parameter int ROW_BITS = 9,
    parameter int COL_BITS = 8,
    parameter int DATA_W   = 8,
    parameter int PAUSE_W  = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [PAUSE_W-1:0]           pause_cycles_i,
    output logic [ROW_BITS+COL_BITS-1:0] mem_addr_o,
    output logic                         mem_we_o,
    output logic                         mem_re_o,
    output logic [DATA_W-1:0]            mem_wdata_o,
    input  logic [DATA_W-1:0]            mem_rdata_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         fail_o,
    output logic [ROW_BITS+COL_BITS-1:0] fail_addr_o,
    output logic                         fail_exp_o
);
    localparam int ADDR_W = ROW_BITS + COL_BITS;

    seq_state_t         state_q;
    logic               bg_q;
    logic [PAUSE_W-1:0] pause_q;
    logic               launch_w, walk_last, skip_w, expire_w, waiting_w;

    assign launch_w = (state_q == ST_IDLE) && start_i;

    rps_addr_walk #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_walk (
        .clk(clk), .rst_n(rst_n), .clr_i(launch_w),
        .step_i((state_q == ST_WRITE) || (state_q == ST_READ)),
        .addr_o(mem_addr_o), .last_o(walk_last)
    );

    rps_hold_timer #(.ADDR_W(ADDR_W), .PAUSE_W(PAUSE_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clr_i(launch_w || (state_q == ST_FLUSH)),
        .tick_i(state_q == ST_WRITE),
        .load_i((state_q == ST_WRITE) && walk_last),
        .pause_i(pause_q),
        .skip_o(skip_w), .expire_o(expire_w), .waiting_o(waiting_w)
    );

    rps_read_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_check (
        .clk(clk), .rst_n(rst_n), .clr_i(launch_w),
        .rd_en_i(state_q == ST_READ), .rd_addr_i(mem_addr_o),
        .exp_i(bg_q), .rdata_i(mem_rdata_i),
        .fail_o(fail_o), .fail_addr_o(fail_addr_o), .fail_exp_o(fail_exp_o)
    );

    // Element sequencing, background selection and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bg_q    <= 1'b0;
            pause_q <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_WRITE;
                    bg_q    <= 1'b0;
                    pause_q <= pause_cycles_i;
                end
                ST_WRITE: if (walk_last) state_q <= skip_w ? ST_READ : ST_WAIT;
                ST_WAIT:  if (expire_w)  state_q <= ST_READ;
                ST_READ:  if (walk_last) state_q <= ST_FLUSH;
                ST_FLUSH: begin
                    if (!bg_q) begin
                        bg_q    <= 1'b1;
                        state_q <= ST_WRITE;
                    end else begin
                        state_q <= ST_IDLE;
                        done_o  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_we_o    = (state_q == ST_WRITE);
    assign mem_re_o    = (state_q == ST_READ);
    assign mem_wdata_o = {DATA_W{bg_q}};
    assign busy_o      = (state_q != ST_IDLE);

    // R5: a fully covered pause hands over straight to reading address 0
    a_r5_direct_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && walk_last && skip_w) |=> (mem_re_o && mem_addr_o == '0));
    // R6: no access while the timer is still running
    a_r6_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
        waiting_w |-> (!mem_we_o && !mem_re_o));
    // R8: done lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9: a start seen while running does not restart or stop the test
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !(state_q == ST_FLUSH && bg_q)) |=> busy_o);
endmodule

// File: tb/retention_pause_seq_test.sv
module retention_pause_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int RB = 3;
    localparam int CB = 2;
    localparam int AW = RB + CB;
    localparam int NW = 1 << AW;
    localparam int DW = 8;
    localparam int PW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [PW-1:0] pause_i = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_we, mem_re;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy, done, fail, fail_exp;
    logic [AW-1:0] fail_addr;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // Bench fault model: two cells that may fail to hold a given value.
    bit       fen [2];
    int       fa  [2];
    int       fb  [2];
    bit       fp  [2];
    logic [DW-1:0] mem [NW];

    always #(CLK_PERIOD/2) clk = ~clk;

    retention_pause_seq #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW), .PAUSE_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pause_cycles_i(pause_i),
        .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .busy_o(busy), .done_o(done), .fail_o(fail),
        .fail_addr_o(fail_addr), .fail_exp_o(fail_exp)
    );

    function automatic logic [DW-1:0] corrupt(logic [DW-1:0] d, int a);
        logic [DW-1:0] r = d;
        for (int f = 0; f < 2; f++)
            if (fen[f] && a == fa[f] && r[fb[f]] == fp[f]) r[fb[f]] = ~fp[f];
        return r;
    endfunction

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= corrupt(mem[mem_addr], int'(mem_addr));
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected operation at cycle k of a run: 0 idle, 1 write, 2 read.
    function automatic int exp_op(int k, int p, output int addr, output bit bg);
        int w = (p > NW) ? p - NW : 0;
        int len = 2 * NW + w + 1;
        int o = k % len;
        bg = (k >= len);
        addr = 0;
        if (o < NW) begin addr = o; return 1; end
        if (o < NW + w) return 0;
        if (o < 2 * NW + w) begin addr = o - NW - w; return 2; end
        return 0;
    endfunction

    task automatic run(int p, bit inj);
        int w = (p > NW) ? p - NW : 0;
        int total = 2 * (2 * NW + w + 1);
        int e2 = 0, e3 = 0, e6 = 0, e8 = 0, e10 = 0, e9 = 0;
        int first_re = -1;
        int best = -1;
        bit bpol = 0;
        for (int pol = 0; pol < 2; pol++)
            if (best < 0)
                for (int f = 0; f < 2; f++)
                    if (fen[f] && fp[f] == pol && (best < 0 || fa[f] < best)) begin
                        best = fa[f];
                        bpol = pol[0];
                    end
        @(negedge clk);
        pause_i = p[PW-1:0];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k <= total + 1; k++) begin
            if (k < total) begin
                int a;
                bit bg;
                int op = exp_op(k, p, a, bg);
                if (!busy) e9++;
                if (done) e8++;
                if (mem_re && first_re < 0) first_re = k;
                if (op == 0) begin
                    if (mem_we || mem_re) e6++;
                end else begin
                    if (mem_we != (op == 1) || mem_re != (op == 2)) e2++;
                    if (int'(mem_addr) != a) e3++;
                    if (op == 1 && mem_wdata != {DW{bg}}) e10++;
                end
            end else if (k == total) begin
                chk(done == 1'b1 && busy == 1'b0, "R8", "done pulse at end", int'({done, busy}), 2);
                chk(fail == (best >= 0), "R7", "fail flag", int'(fail), int'(best >= 0));
                if (best >= 0) begin
                    chk(int'(fail_addr) == best, "R7", "first fail address", int'(fail_addr), best);
                    chk(fail_exp == bpol, "R7", "expected bit", int'(fail_exp), int'(bpol));
                end
            end else begin
                chk(done == 1'b0, "R8", "done falls after one cycle", int'(done), 0);
            end
            start_i = (inj && (k == 7 || k == total - 2));
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(e2 == 0, "R2", "element access pattern errors", e2, 0);
        chk(e3 == 0, "R3", "fast-row address errors", e3, 0);
        chk(e6 == 0, "R6", "access during wait", e6, 0);
        chk(e10 == 0, "R10", "write data errors", e10, 0);
        chk(e8 == 0, "R8", "early done cycles", e8, 0);
        chk(first_re == ((p > NW) ? p : NW), "R4", "first read cycle", first_re, (p > NW) ? p : NW);
        if (p <= NW) chk(first_re == NW, "R5", "read right after sweep", first_re, NW);
        if (inj) chk(e9 == 0, "R9", "busy dropped after mid-run start", e9, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_faults(bit e0, int a0, int b0, bit p0, bit e1, int a1, int b1, bit p1);
        fen[0] = e0; fa[0] = a0; fb[0] = b0; fp[0] = p0;
        fen[1] = e1; fa[1] = a1; fb[1] = b1; fp[1] = p1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NW; i++) mem[i] = '0;
        set_faults(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(!busy && !done && !fail && !mem_we && !mem_re, "R1", "reset outputs",
            int'({busy, done, fail, mem_we, mem_re}), 0);
        run(0, 0);
        set_faults(1, 0, 3, 1, 0, 0, 0, 0);
        run(NW, 0);
        set_faults(1, NW - 1, 7, 0, 0, 0, 0, 0);
        run(NW + 1, 1);
        set_faults(0, 0, 0, 0, 0, 0, 0, 0);
        run(NW - 1, 0);
        set_faults(1, 9, 1, 0, 1, 4, 6, 0);
        run(150, 0);
        set_faults(1, 2, 0, 1, 1, 20, 5, 0);
        run(NW + 2, 1);
        for (int r = 0; r < 8; r++) begin
            set_faults($urandom_range(1, 0) == 1, $urandom_range(NW - 1, 0), $urandom_range(DW - 1, 0),
                       $urandom_range(1, 0) == 1,
                       $urandom_range(1, 0) == 1, $urandom_range(NW - 1, 0), $urandom_range(DW - 1, 0),
                       $urandom_range(1, 0) == 1);
            run($urandom_range(120, 0), 1);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule